// File: doc/BRIEF.md
# Duty-Cycled Supply Voltage Monitor

This block supervises a battery or supply rail without keeping the measurement path powered all the time. While software has it switched on, it counts ticks of a slow clock and opens a short power-up window at the start of every measurement period. During that window it drives a power request to an external sense front end and a 5-bit converter. It captures the first conversion result that the converter strobes back inside the window. Each code step is 50 mV: code 0 stands for a rail under 1.7 V, code 1 for 1.7 V to 1.75 V, and code 31 for a rail above 3.2 V.

Each captured code is compared with a programmable threshold. A low-supply event is declared only after a run of consecutive samples below the threshold, which filters out single dips. The event sets a sticky status flag. When the interrupt enable is also set, the flag pulls an active-low interrupt line. Software reads the status to confirm the cause, and that read clears the flag. Sampling continues in the chip's sleep state for as long as the enable bit is set, because the block runs only from its own enable and the slow tick.

Top module: `vsm_monitor`

## Requirements
- R1: After reset, `enable` and `irq_en` are 0, `thr` is 0x14 (decimal 20), `level` is 0, `stat_flag` is 0, `irq_n` is 1 and `fe_pwr` is 0.
- R2: While enabled, `fe_pwr` is 1 for the first WINDOW_TICKS slow ticks of every PERIOD_TICKS-tick period and 0 for the rest. Writing the enable bit from 0 to 1 starts a new period, with the window open from the next clock.
- R3: A converter strobe (`adc_valid`) updates `level` on the following clock only when `fe_pwr` is 1 and no sample has yet been taken in the current window. Strobes outside the window, and any later strobe in the same window, leave `level` unchanged.
- R4: A sample counts as low only when its code is strictly less than `thr` (unsigned). A sample equal to or above `thr` clears the run of low samples.
- R5: `stat_flag` becomes 1 on the clock after the LOW_RUN-th consecutive low sample (default four), and not after fewer.
- R6: Once an event is declared, the run count starts again from zero. Another event needs a further LOW_RUN consecutive low samples.
- R7: `irq_n` is 0 exactly when `stat_flag` and `irq_en` are both 1. With `irq_en` at 0, the flag still sets but `irq_n` stays 1.
- R8: A pulse on `stat_rd` clears `stat_flag` on the next clock. If an event is declared in the same cycle as the read, the flag ends up set.
- R9: With the enable bit at 0, `fe_pwr` is 0, strobes are ignored, `level` keeps its last value and the low-sample run is cleared.
- R10: A write on `thr_we` loads `thr` on the next clock, and every later sample is compared with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock tick |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_enable | input | 1 | Monitor enable value to write |
| ctl_irq_en | input | 1 | Interrupt enable value to write |
| thr_we | input | 1 | Write strobe for the threshold |
| thr_wdata | input | 5 | Threshold value to write |
| stat_rd | input | 1 | Status read pulse; clears the flag |
| adc_valid | input | 1 | Converter result strobe |
| adc_code | input | 5 | Converter result code |
| fe_pwr | output | 1 | Power request to front end and converter |
| enable | output | 1 | Current enable bit |
| irq_en | output | 1 | Current interrupt enable bit |
| thr | output | 5 | Current threshold |
| level | output | 5 | Last captured supply code |
| stat_flag | output | 1 | Sticky low-supply status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The status flag has a set source and a clear source, and both can act in the same clock. The set source is the final low sample of a run. The clear source is a software status read. The bench leaves the flag set from an earlier event, runs up three new low samples, and then pulses `stat_rd` in the same cycle as the strobe that completes the fourth. It expects the flag to be 1 after that edge. A plain read on a later cycle must then bring the flag to 0. A design that lets the read win would leave the flag at 0 after the first edge and so drop a real event.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] THR_RST = 5'h14;
endpackage

// File: rtl/vsm_duty_timer.sv
module vsm_duty_timer #(
  parameter int PERIOD_TICKS = 32768,
  parameter int WINDOW_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  output logic win_open
);
  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] WIN  = CNT_W'(WINDOW_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign win_open = run_en && (cnt_q < WIN);
endmodule

// File: rtl/vsm_sampler.sv
module vsm_sampler import vsm_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_open,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] thr,
  output logic [CODE_W-1:0] level_q,
  output logic              accept,
  output logic              below
);
  logic              taken_q, taken_d;
  logic [CODE_W-1:0] level_d;

  assign accept = win_open && adc_valid && !taken_q;
  assign below  = (adc_code < thr);

  always_comb begin
    taken_d = taken_q;
    level_d = level_q;
    if (!win_open) begin
      taken_d = 1'b0;
    end else if (accept) begin
      taken_d = 1'b1;
      level_d = adc_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      level_q <= '0;
    end else begin
      taken_q <= taken_d;
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/vsm_debounce.sv
module vsm_debounce #(
  parameter int LOW_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic accept,
  input  logic below,
  output logic event_o
);
  localparam int RCW = $clog2(LOW_RUN + 1);
  localparam logic [RCW-1:0] LAST = RCW'(LOW_RUN - 1);

  logic [RCW-1:0] run_q, run_d;

  assign event_o = run_en && accept && below && (run_q == LAST);

  always_comb begin
    run_d = run_q;
    if (!run_en) begin
      run_d = '0;
    end else if (accept) begin
      if (!below || event_o) run_d = '0;
      else                   run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/vsm_monitor.sv
module vsm_monitor import vsm_pkg::*; #(
  parameter int PERIOD_TICKS = 32768,
  parameter int WINDOW_TICKS = 8,
  parameter int LOW_RUN      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              ctl_irq_en,
  input  logic              thr_we,
  input  logic [CODE_W-1:0] thr_wdata,
  input  logic              stat_rd,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  output logic              fe_pwr,
  output logic              enable,
  output logic              irq_en,
  output logic [CODE_W-1:0] thr,
  output logic [CODE_W-1:0] level,
  output logic              stat_flag,
  output logic              irq_n
);
  logic              en_q, en_d, ie_q, ie_d, flag_q, flag_d;
  logic [CODE_W-1:0] thr_q, thr_d;
  logic              win_open, accept, below, low_event;

  vsm_duty_timer #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .WINDOW_TICKS(WINDOW_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(en_q), .tick(slow_tick), .win_open(win_open)
  );

  vsm_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .adc_valid(adc_valid),
    .adc_code(adc_code), .thr(thr_q), .level_q(level), .accept(accept), .below(below)
  );

  vsm_debounce #(.LOW_RUN(LOW_RUN)) u_debounce (
    .clk(clk), .rst_n(rst_n), .run_en(en_q), .accept(accept), .below(below),
    .event_o(low_event)
  );

  always_comb begin
    en_d   = ctl_we ? ctl_enable : en_q;
    ie_d   = ctl_we ? ctl_irq_en : ie_q;
    thr_d  = thr_we ? thr_wdata  : thr_q;
    flag_d = flag_q;
    if (stat_rd)   flag_d = 1'b0;
    if (low_event) flag_d = 1'b1;   // set wins over a same-cycle read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      thr_q  <= THR_RST;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      thr_q  <= thr_d;
      flag_q <= flag_d;
    end
  end

  assign fe_pwr    = win_open;
  assign enable    = en_q;
  assign irq_en    = ie_q;
  assign thr       = thr_q;
  assign stat_flag = flag_q;
  assign irq_n     = ~(flag_q & ie_q);
endmodule

// File: rtl/vsm_monitor_chk.sv
module vsm_monitor_chk import vsm_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              fe_pwr,
  input logic              enable,
  input logic              irq_en,
  input logic              adc_valid,
  input logic              stat_rd,
  input logic [CODE_W-1:0] level,
  input logic              stat_flag,
  input logic              irq_n
);
  assert_pwr_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pwr |-> enable);

  assert_level_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_pwr |=> $stable(level));

  assert_flag_from_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flag) |-> $past(adc_valid && fe_pwr));

  assert_flag_cleared_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_flag) |-> $past(stat_rd));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat_flag && irq_en));
endmodule

bind vsm_monitor vsm_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fe_pwr(fe_pwr), .enable(enable), .irq_en(irq_en),
  .adc_valid(adc_valid), .stat_rd(stat_rd), .level(level), .stat_flag(stat_flag),
  .irq_n(irq_n)
);

// File: tb/tb_vsm_monitor.sv
`timescale 1ns/1ps
module tb_vsm_monitor;
  localparam int P = 8;
  localparam int W = 3;
  localparam int N = 4;

  logic clk, rst_n, slow_tick, ctl_we, ctl_enable, ctl_irq_en, thr_we, stat_rd, adc_valid;
  logic [4:0] thr_wdata, adc_code, thr, level;
  logic fe_pwr, enable, irq_en, stat_flag, irq_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  vsm_monitor #(.PERIOD_TICKS(P), .WINDOW_TICKS(W), .LOW_RUN(N)) dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ctl_we(ctl_we),
    .ctl_enable(ctl_enable), .ctl_irq_en(ctl_irq_en), .thr_we(thr_we),
    .thr_wdata(thr_wdata), .stat_rd(stat_rd), .adc_valid(adc_valid),
    .adc_code(adc_code), .fe_pwr(fe_pwr), .enable(enable), .irq_en(irq_en),
    .thr(thr), .level(level), .stat_flag(stat_flag), .irq_n(irq_n)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1; cyc(); slow_tick = 0;
    end
  endtask

  task automatic strobe(input logic [4:0] c);
    adc_valid = 1; adc_code = c; cyc(); adc_valid = 0;
  endtask

  // one sample at window start, then return to the next window start
  task automatic sample(input logic [4:0] c);
    strobe(c); ticks(P);
  endtask

  task automatic wr_ctl(input logic e, input logic ie);
    ctl_we = 1; ctl_enable = e; ctl_irq_en = ie; cyc(); ctl_we = 0;
  endtask

  task automatic wr_thr(input logic [4:0] v);
    thr_we = 1; thr_wdata = v; cyc(); thr_we = 0;
  endtask

  task automatic rd_stat();
    stat_rd = 1; cyc(); stat_rd = 0;
  endtask

  task automatic t_reset();
    check("R1 enable", enable, 0);
    check("R1 irq_en", irq_en, 0);
    check("R1 thr", thr, 20);
    check("R1 level", level, 0);
    check("R1 flag", stat_flag, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 fe_pwr", fe_pwr, 0);
  endtask

  task automatic t_window();
    wr_ctl(1, 0);
    check("R2 open after enable", fe_pwr, 1);
    ticks(W - 1);
    check("R2 open last tick", fe_pwr, 1);
    ticks(1);
    check("R2 closed", fe_pwr, 0);
    ticks(P - W - 1);
    check("R2 still closed", fe_pwr, 0);
    ticks(1);
    check("R2 reopened", fe_pwr, 1);
  endtask

  task automatic t_capture();
    ticks(W);
    strobe(5'd7);
    check("R3 outside window ignored", level, 0);
    ticks(P - W);
    strobe(5'd9);
    check("R3 captured", level, 9);
    strobe(5'd3);
    check("R3 second strobe ignored", level, 9);
    ticks(P);
    sample(5'd25);
    check("R3 next window captured", level, 25);
  endtask

  task automatic t_debounce();
    for (int i = 0; i < 3; i++) begin
      sample(5'd5);
      check("R5 no flag early", stat_flag, 0);
    end
    sample(5'd5);
    check("R5 flag on fourth", stat_flag, 1);
    rd_stat();
    check("R8 read clears", stat_flag, 0);
  endtask

  task automatic t_compare();
    wr_thr(5'd10);
    check("R10 thr written", thr, 10);
    for (int i = 0; i < 3; i++) sample(5'd9);
    sample(5'd10);
    check("R4 equal not low", stat_flag, 0);
    for (int i = 0; i < 3; i++) sample(5'd9);
    check("R4 run restarted", stat_flag, 0);
    sample(5'd9);
    check("R4 strict below counts", stat_flag, 1);
    rd_stat();
  endtask

  task automatic t_rearm();
    for (int i = 0; i < 3; i++) sample(5'd9);
    check("R6 no early re-event", stat_flag, 0);
    sample(5'd9);
    check("R6 second event", stat_flag, 1);
  endtask

  task automatic t_same();
    for (int i = 0; i < 3; i++) sample(5'd9);
    adc_valid = 1; adc_code = 5'd9; stat_rd = 1;
    cyc();
    adc_valid = 0; stat_rd = 0;
    check("R8 set wins over read", stat_flag, 1);
    ticks(P);
    rd_stat();
    check("R8 later read clears", stat_flag, 0);
  endtask

  task automatic t_irq();
    for (int i = 0; i < 4; i++) sample(5'd9);
    check("R7 flag with ie off", stat_flag, 1);
    check("R7 irq_n high with ie off", irq_n, 1);
    wr_ctl(1, 1);
    check("R7 irq_n low", irq_n, 0);
    rd_stat();
    check("R7 irq_n released", irq_n, 1);
  endtask

  task automatic t_disable();
    sample(5'd4);
    sample(5'd4);
    wr_ctl(0, 1);
    check("R9 fe_pwr off", fe_pwr, 0);
    strobe(5'd15);
    check("R9 strobe ignored", level, 4);
    ticks(3);
    check("R9 stays off", fe_pwr, 0);
    check("R9 level held", level, 4);
    wr_ctl(1, 1);
    for (int i = 0; i < 3; i++) sample(5'd4);
    check("R9 run cleared", stat_flag, 0);
    sample(5'd4);
    check("R9 fresh run flags", stat_flag, 1);
    check("R7 irq asserted", irq_n, 0);
    rd_stat();
  endtask

  task automatic t_thr();
    sample(5'd12);
    check("R10 level 12", level, 12);
    wr_thr(5'd13);
    for (int i = 0; i < 4; i++) sample(5'd12);
    check("R10 new thr used", stat_flag, 1);
    rd_stat();
  endtask

  initial begin
    rst_n = 0; slow_tick = 0; ctl_we = 0; ctl_enable = 0; ctl_irq_en = 0;
    thr_we = 0; thr_wdata = 0; stat_rd = 0; adc_valid = 0; adc_code = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    t_reset();
    t_window();
    t_capture();
    t_debounce();
    t_compare();
    t_rearm();
    t_same();
    t_irq();
    t_disable();
    t_thr();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule